// File: doc/BRIEF.md
# Half-Integer Predivider Clock Generator

This block turns one of three selectable source tick streams into a programmable output clock for a video or audio master clock. All logic runs on one fast reference clock. Each source appears as a one-cycle tick strobe at twice that source's rate. A predivider of 2, 2.5 or 3 is therefore a whole count of 4, 5 or 6 doubled ticks, so no logic has to use both clock edges. After the predivider, an integer divider of 1 to 127 sets the output rate at 2·fsrc/((p+3)·div).

Software programs the generator through a single 32-bit control word on a simple write/read bus. The control word holds an enable, a two-bit source code, a two-bit predivider code and a seven-bit divider. The generator drives two outputs: a one-cycle pulse at the end of each output period, usable as a clock enable, and a square wave that is high for the first half of each period. A running period always finishes at its full length. New settings are loaded only at a period boundary, or at once if the generator is idle, so the output never produces a short pulse.

Top module: `hpd_clkgen`

## Requirements
- R1: `reg_rdata` always shows the full 32-bit word last written through `reg_wr`/`reg_wdata`, including unused and reserved bits. It reads 0 after reset.
- R2: Bit 15 of the control word is the enable. While the active setting has it clear, `gen_pulse` and `gen_sq` stay low.
- R3: Bits 14:13 pick the source. Codes 00 and 01 both count `src_tick[0]`, code 10 counts `src_tick[1]` and code 11 counts `src_tick[2]`. Ticks of the other sources are ignored.
- R4: Bits 9:8 hold the predivider code p. Codes 1, 2 and 3 divide the selected ticks by 4, 5 and 6, which is 2, 2.5 and 3 of the undoubled source. Code 0 stops the output.
- R5: Bits 6:0 hold the divider, with a working range of 1 to 127. A value of 0 stops the output.
- R6: While running, an output period lasts exactly (p+3)·div selected ticks. `gen_pulse` is high for one cycle at the end of each period, which gives an output rate of 2·fsrc/((p+3)·div).
- R7: `gen_sq` rises at the start of each period and stays high for floor((p+3)·div/2) selected ticks, then is low for the rest of the period.
- R8: A written setting takes effect only when the running period ends, so the period in progress keeps its full length. When the generator is idle, a new setting takes effect in the next cycle.
- R9: The reserved bit 7 and bits 31:16 and 12:10 are stored but do not change the output.
- R10: After reset both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word value to write |
| reg_rdata | output | 32 | Stored control word |
| src_tick | input | 3 | One-cycle ticks of each source at twice its rate |
| gen_pulse | output | 1 | One-cycle pulse at the end of each output period |
| gen_sq | output | 1 | Square output, high for the first half of each period |

## Verification
The bench gives each source a different tick spacing: every cycle, every second cycle and every third cycle. A mix-up in the source code mapping, such as treating 01 as a PLL source, would therefore show up as a period that is too long by a whole factor. It checks the period and the high time for all three predivider codes and for the largest divider, 127. An off-by-one predivider count would show up as a period that is 1/(p+3) too long. A wrongly rounded half count would show up as a skewed duty cycle. The bench also rewrites the setting in the middle of a long period. A design that loaded the setting at once would cut that period short or restart it, and the bench would see the pulse arrive early. Finally, it writes a predivider of 0, a divider of 0 and a clear enable, and checks that no pulse and no high level leak out in any of these cases.

// File: rtl/hpd_clkgen_pkg.sv
package hpd_clkgen_pkg;

   // Field widths of the control word
   localparam int DIV_W  = 7;
   localparam int PDIV_W = 2;
   localparam int SRC_W  = 2;

   // Field positions decoded by the generator
   localparam int EN_POS   = 15;
   localparam int SRC_LSB  = 13;
   localparam int PDIV_LSB = 8;
   localparam int RSV_POS  = 7;
   localparam int DIV_LSB  = 0;

   // Predivider count offset: code p counts p+3 doubled ticks
   localparam int PRE_OFS  = 3;
   localparam int PRE_W    = 3;

   typedef struct packed {
      logic              en;
      logic [SRC_W-1:0]  src;
      logic [PDIV_W-1:0] pdiv;
      logic [DIV_W-1:0]  div;
   } gen_cfg_t;

   // Source code to tick input: 00/01 -> 0, 10 -> 1, 11 -> 2
   function automatic int src_index(input logic [SRC_W-1:0] code);
      int idx;
      case (code)
         2'b10:   idx = 1;
         2'b11:   idx = 2;
         default: idx = 0;
      endcase
      return idx;
   endfunction

   function automatic logic cfg_live(input gen_cfg_t c);
      return c.en && (c.pdiv != '0) && (c.div != '0);
   endfunction

endpackage

// File: rtl/hpd_clkgen_ctrl_reg.sv
module hpd_clkgen_ctrl_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr) begin
         q <= wdata;
      end
   end

endmodule

// File: rtl/hpd_clkgen_src_sel.sv
module hpd_clkgen_src_sel
   import hpd_clkgen_pkg::*;
#(
   parameter int NSRC = 3
) (
   input  logic [NSRC-1:0]  src_tick,
   input  logic [SRC_W-1:0] src_code,
   output logic             tick
);

   logic [NSRC-1:0] hit;

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_src
         assign hit[g] = src_tick[g] && (src_index(src_code) == g);
      end
   endgenerate

   assign tick = |hit;

endmodule

// File: rtl/hpd_clkgen_div_core.sv
module hpd_clkgen_div_core
   import hpd_clkgen_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  gen_cfg_t cfg_req,
   input  logic     tick,
   output gen_cfg_t act_cfg,
   output logic     act_live,
   output logic     gen_pulse,
   output logic     gen_sq
);

   localparam int POS_W = DIV_W + PRE_W;

   logic [PRE_W-1:0] pre_q, pre_d;
   logic [DIV_W-1:0] post_q, post_d;
   logic [POS_W-1:0] pos_q, pos_d;
   gen_cfg_t         act_d;
   logic [PRE_W-1:0] pre_last;
   logic             pre_tc;
   logic             period_end;
   logic             live_d;
   logic [POS_W-1:0] ratio_d;
   logic [POS_W-1:0] half_d;

   always_comb begin
      act_live   = cfg_live(act_cfg);
      pre_last   = {1'b0, act_cfg.pdiv} + PRE_W'(PRE_OFS - 1);
      pre_tc     = act_live && tick && (pre_q == pre_last);
      period_end = pre_tc && (post_q == act_cfg.div - DIV_W'(1));

      act_d  = act_cfg;
      pre_d  = pre_q;
      post_d = post_q;
      pos_d  = pos_q;

      if (period_end || !act_live) begin
         // Period boundary or idle: pick up the programmed setting
         act_d  = cfg_req;
         pre_d  = '0;
         post_d = '0;
         pos_d  = '0;
      end else if (tick) begin
         pre_d  = pre_tc ? '0 : pre_q + PRE_W'(1);
         post_d = pre_tc ? post_q + DIV_W'(1) : post_q;
         pos_d  = pos_q + POS_W'(1);
      end

      live_d  = cfg_live(act_d);
      ratio_d = POS_W'({1'b0, act_d.pdiv} + PRE_W'(PRE_OFS)) * POS_W'(act_d.div);
      half_d  = ratio_d >> 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_cfg   <= '0;
         pre_q     <= '0;
         post_q    <= '0;
         pos_q     <= '0;
         gen_pulse <= 1'b0;
         gen_sq    <= 1'b0;
      end else begin
         act_cfg   <= act_d;
         pre_q     <= pre_d;
         post_q    <= post_d;
         pos_q     <= pos_d;
         gen_pulse <= period_end;
         gen_sq    <= live_d && (pos_d < half_d);
      end
   end

endmodule

// File: rtl/hpd_clkgen.sv
module hpd_clkgen
   import hpd_clkgen_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NSRC   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NSRC-1:0]   src_tick,
   output logic              gen_pulse,
   output logic              gen_sq
);

   generate
      if (DATA_W <= EN_POS) begin : g_bad_width
         $error("hpd_clkgen: DATA_W must hold the enable bit");
      end
      if (NSRC != 3) begin : g_bad_src
         $error("hpd_clkgen: the source code maps exactly three sources");
      end
   endgenerate

   gen_cfg_t cfg_req;
   gen_cfg_t act_cfg;
   logic     act_live;
   logic     sel_tick;
   logic     unused_bits;

   hpd_clkgen_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .wdata (reg_wdata),
      .q     (reg_rdata)
   );

   always_comb begin
      cfg_req.en   = reg_rdata[EN_POS];
      cfg_req.src  = reg_rdata[SRC_LSB  +: SRC_W];
      cfg_req.pdiv = reg_rdata[PDIV_LSB +: PDIV_W];
      cfg_req.div  = reg_rdata[DIV_LSB  +: DIV_W];
   end

   assign unused_bits = ^{reg_rdata[DATA_W-1:EN_POS+1],
                          reg_rdata[SRC_LSB-1:PDIV_LSB+PDIV_W],
                          reg_rdata[RSV_POS]};

   hpd_clkgen_src_sel #(.NSRC(NSRC)) u_sel (
      .src_tick (src_tick),
      .src_code (act_cfg.src),
      .tick     (sel_tick)
   );

   hpd_clkgen_div_core u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_req   (cfg_req),
      .tick      (sel_tick),
      .act_cfg   (act_cfg),
      .act_live  (act_live),
      .gen_pulse (gen_pulse),
      .gen_sq    (gen_sq)
   );

endmodule

// File: rtl/hpd_clkgen_chk.sv
module hpd_clkgen_chk #(
   parameter int DATA_W = 32,
   parameter int CFG_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              gen_pulse,
   input logic              gen_sq,
   input logic              act_live,
   input logic [CFG_W-1:0]  act_cfg
);

   // R1
   wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> reg_rdata == $past(reg_wdata));

   // R1
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> $stable(reg_rdata));

   // R2
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_live |-> !gen_sq);

   // R7
   period_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_pulse && act_live) |-> gen_sq);

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_pulse |=> !gen_pulse);

   // R8
   reload_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_cfg != $past(act_cfg)) && $past(act_live)) |-> gen_pulse);

endmodule

bind hpd_clkgen hpd_clkgen_chk #(.DATA_W(DATA_W), .CFG_W($bits(hpd_clkgen_pkg::gen_cfg_t))) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .gen_pulse (gen_pulse),
   .gen_sq    (gen_sq),
   .act_live  (act_live),
   .act_cfg   (act_cfg)
);

// File: tb/hpd_clkgen_bench.sv
`timescale 1ns/1ps
module hpd_clkgen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  src_tick = '0;
   logic        gen_pulse;
   logic        gen_sq;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;

   hpd_clkgen u_hpd_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .src_tick  (src_tick),
      .gen_pulse (gen_pulse),
      .gen_sq    (gen_sq)
   );

   // Source 0 ticks every cycle, source 1 every second, source 2 every third
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         src_tick[0] = 1'b1;
         src_tick[1] = (cyc % 2) == 0;
         src_tick[2] = (cyc % 3) == 0;
      end
   end

   // Control word: [15] enable, [14:13] source, [9:8] predivider code, [6:0] divider
   localparam int NVEC = 6;
   localparam logic [31:0] VEC_WORD [NVEC] = '{
      32'h0000_8101,   // src 00, p=1, div=1   -> 4 ticks,   spacing 1
      32'h0000_A203,   // src 01, p=2, div=3   -> 15 ticks,  spacing 1
      32'h0000_C302,   // src 10, p=3, div=2   -> 12 ticks,  spacing 2
      32'h0000_E105,   // src 11, p=1, div=5   -> 20 ticks,  spacing 3
      32'h5A00_83FF,   // src 00, p=3, div=127 + reserved/unused bits -> 762
      32'h0000_E207    // src 11, p=2, div=7   -> 35 ticks,  spacing 3
   };
   localparam int VEC_PER [NVEC] = '{4, 15, 24, 60, 762, 105};
   localparam int VEC_HI  [NVEC] = '{2, 7, 12, 30, 381, 51};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_reg(input logic [31:0] v);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   // Called right after a sample; runs to the next pulse sample
   task automatic measure(output int len, output int hi);
      len = 0;
      hi  = gen_sq ? 1 : 0;
      forever begin
         @(negedge clk);
         len++;
         if (gen_pulse || len > 20000) break;
         if (gen_sq) hi++;
      end
   endtask

   task automatic quiet_window(input int n, output int pulses, output int highs);
      pulses = 0;
      highs  = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (gen_pulse) pulses++;
         if (gen_sq) highs++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int len, hi, pulses, highs;

      repeat (4) @(negedge clk);
      // R10 / R1: reset state
      check(reg_rdata == 32'h0, "R1 reset read", int'(reg_rdata), 0);
      check(gen_pulse == 1'b0, "R10 reset pulse", int'(gen_pulse), 0);
      check(gen_sq == 1'b0, "R10 reset square", int'(gen_sq), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(gen_sq == 1'b0, "R10 idle square", int'(gen_sq), 0);

      // R1: full word readback
      write_reg(32'hA5A5_5A5A);
      check(reg_rdata == 32'hA5A5_5A5A, "R1 readback A", int'(reg_rdata), int'(32'hA5A5_5A5A));
      write_reg(32'hFFFF_FFFF);
      check(reg_rdata == 32'hFFFF_FFFF, "R1 readback B", int'(reg_rdata), int'(32'hFFFF_FFFF));

      // R3 R4 R5 R6 R7 R9: table of settings
      for (int v = 0; v < NVEC; v++) begin
         write_reg(VEC_WORD[v]);
         measure(len, hi);
         measure(len, hi);
         measure(len, hi);
         check(len == VEC_PER[v], $sformatf("R3 R4 R5 R6 R9 period vec%0d", v), len, VEC_PER[v]);
         check(hi == VEC_HI[v], $sformatf("R7 high time vec%0d", v), hi, VEC_HI[v]);
      end

      // R8: rewrite in the middle of a 400-tick period
      write_reg(32'h0000_8164);
      measure(len, hi);
      measure(len, hi);
      len = 0;
      forever begin
         @(negedge clk);
         len++;
         if (len == 50) begin reg_wr = 1'b1; reg_wdata = 32'h0000_8101; end
         if (len == 51) reg_wr = 1'b0;
         if (gen_pulse || len > 20000) break;
      end
      check(len == 400, "R8 running period kept", len, 400);
      measure(len, hi);
      check(len == 4, "R8 new period applied", len, 4);

      // R2: enable clear
      write_reg(32'h0000_0101);
      repeat (20) @(negedge clk);
      quiet_window(2000, pulses, highs);
      check(pulses == 0, "R2 disabled pulses", pulses, 0);
      check(highs == 0, "R2 disabled square", highs, 0);

      // R4: predivider code 0
      write_reg(32'h0000_8001);
      repeat (20) @(negedge clk);
      quiet_window(1000, pulses, highs);
      check(pulses + highs == 0, "R4 predivider zero", pulses + highs, 0);

      // R5: divider 0
      write_reg(32'h0000_8100);
      repeat (20) @(negedge clk);
      quiet_window(1000, pulses, highs);
      check(pulses + highs == 0, "R5 divider zero", pulses + highs, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule